// File: doc/BRIEF.md
# Sleep Mode and Wake-up Controller

This controller decides when a microcontroller core stops its clock and which events bring it back. A sleep request takes effect only when the software-controlled sleep-enable input is high in the same cycle that the sleep instruction strobe fires. A two-bit mode select then picks one of two kinds of sleep.

In light sleep, only the CPU clock is gated. Any enabled interrupt restarts the core on the next cycle, and so do the timer and serial requests. In deep sleep, the main oscillator is also stopped. Only the pin interrupts, an external reset and an enabled watchdog reset can end deep sleep. In deep sleep, every pin interrupt is sensed as active-low level, whatever edge sense is configured. A level request must be seen active on two consecutive rising edges of the slow watchdog clock before it is accepted.

The controller runs on an always-on clock. The slow clock is brought in through a synchroniser. After deep sleep the oscillator is given a fixed number of start-up cycles. A one-cycle wake strobe then goes out, together with a flag that selects the reset vector when the wake cause was a reset. The core uses this flag to choose between resuming after the sleep instruction and jumping to the reset vector.

States:
- `ST_RUN`: clock on.
- `ST_IDLE`: light sleep.
- `ST_DEEP`: oscillator stopped.
- `ST_RESTART`: oscillator start-up.
- `ST_WAKE`: one-cycle strobe.

Transitions:
- RUN→IDLE and RUN→DEEP on a gated sleep request.
- IDLE→WAKE on an interrupt or a reset.
- DEEP→RESTART on a qualified level or a reset.
- RESTART→WAKE after `START_CYC` cycles.
- WAKE→RUN always.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, `cpu_clk_en`=1, `osc_stop`=0, `wake_pulse`=0 and `rst_vec_sel`=0.
- R2: In the running state, `sleep_exec` with `sleep_en`=0 is ignored and `cpu_clk_en` stays 1. With `sleep_en`=1, sleep starts on the next cycle.
- R3: `mode_sel` 00 (and the reserved 01) selects light sleep: `cpu_clk_en`=0 and `osc_stop`=0.
- R4: In light sleep, the wake strobe is seen one cycle after any of these requests:
  - `timer_irq`;
  - `serial_irq`;
  - an enabled pin request, sensed per bit of `sense_edge`: 1 = falling edge, 0 = low level.
  - Bits 3..0 of `sense_edge` map to `ext_irq_n`, and bits 7..4 map to `fab_irq_n`.
  - A disabled line, or a line that is already low when its sense is edge, does not wake the core.
- R5: `mode_sel` 10 and 11 select deep sleep: `cpu_clk_en`=0 and `osc_stop`=1.
- R6: In deep sleep, enabled pins are sensed as active-low level whatever `sense_edge` holds. Timer and serial requests and disabled pins are ignored.
- R7: A deep-sleep level wake needs the request active on two consecutive sampled rising edges of `slow_clk`. A request that is missing at the second sample starts the count again.
- R8: On leaving deep sleep, `osc_stop` falls at once, and the wake strobe follows `START_CYC` cycles later.
- R9: `wake_pulse` lasts exactly one cycle, with `cpu_clk_en`=1 during it.
- R10: `ext_rst` always wakes the core from sleep, and `wdt_rst` wakes it only when `wdt_en`=1. A reset wake drives `rst_vec_sel`=1 with the strobe; an interrupt wake drives 0.
- R11: Wake latencies in cycles, with `START_CYC`=4:
  - light-sleep interrupt or reset: 1;
  - deep-sleep reset: `START_CYC`+1;
  - deep-sleep level wake, counted from the second slow-clock rise: `START_CYC`+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low block reset |
| sleep_en | input | 1 | Software sleep-enable bit |
| mode_sel | input | 2 | Sleep mode: 00/01 light, 10/11 deep |
| sleep_exec | input | 1 | Sleep instruction strobe |
| ext_irq_n | input | N_EXT | External interrupt pins, low active |
| ext_irq_en | input | N_EXT | External interrupt enables |
| fab_irq_n | input | N_FAB | Fabric interrupt lines, low active |
| fab_irq_en | input | N_FAB | Fabric interrupt enables |
| sense_edge | input | N_EXT+N_FAB | Per-line sense in light sleep, 1 = falling edge |
| timer_irq | input | 1 | Timer interrupt request |
| serial_irq | input | 1 | Serial unit interrupt request |
| wdt_en | input | 1 | Watchdog enable |
| wdt_rst | input | 1 | Watchdog reset request |
| ext_rst | input | 1 | External reset request |
| slow_clk | input | 1 | Slow watchdog clock, sampled |
| cpu_clk_en | output | 1 | CPU clock gate, 1 = running |
| osc_stop | output | 1 | Main oscillator stop |
| wake_pulse | output | 1 | One-cycle wake strobe |
| rst_vec_sel | output | 1 | With the strobe: start at the reset vector |

## Verification
Each result has a fixed latency, counted in clock edges after the stimulus:
- Sleep entry appears one edge after the sleep strobe.
- A light-sleep wake appears one edge after its request.
- A deep-sleep reset wake appears `START_CYC`+1 edges later.
- A level wake appears `START_CYC`+4 edges after the second slow-clock rise: two synchroniser stages, the edge detector, the qualifier, then the state change.

The bench applies inputs at falling edges. After each rising edge it samples at the falling edge and counts how many edges pass until the strobe. It compares that count with these numbers and does not merely wait for the strobe. Checks that expect no wake sample the clock gate and the oscillator-stop output after the slow-clock samples that could have caused one.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_DEEP,
        ST_RESTART,
        ST_WAKE
    } slp_state_t;

    // Upper mode bit set selects a sleep that stops the oscillator.
    function automatic logic mode_is_deep(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/sw_pin_sense.sv
module sw_pin_sense #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] pin_n,
    input  logic [N_LINES-1:0] pin_en,
    input  logic [N_LINES-1:0] sense_edge,
    input  logic               force_level,
    output logic               req_any
);

    logic [N_LINES-1:0] pin_q;
    logic [N_LINES-1:0] req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '1;
        end else begin
            pin_q <= pin_n;
        end
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic lvl_hit;
        logic fall_hit;
        assign lvl_hit  = ~pin_n[g];
        assign fall_hit = pin_q[g] & ~pin_n[g];
        assign req[g]   = pin_en[g] &
                          ((force_level | ~sense_edge[g]) ? lvl_hit : fall_hit);
    end

    assign req_any = |req;

    // R6: a forced-level request is only raised by an enabled low pin
    p_level_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_level && req_any) |-> ((~pin_n & pin_en) != '0));

endmodule

// File: rtl/sw_level_qual.sv
module sw_level_qual #(
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk,
    input  logic arm,
    input  logic level_act,
    output logic qualified
);

    localparam int HW = $clog2(QUAL_SAMPLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   slow_prev;
    logic                   tick;
    logic [HW-1:0]          hits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q    <= '0;
            slow_prev <= 1'b0;
        end else begin
            sync_q    <= {sync_q[SYNC_STAGES-2:0], slow_clk};
            slow_prev <= sync_q[SYNC_STAGES-1];
        end
    end

    assign tick = sync_q[SYNC_STAGES-1] & ~slow_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hits <= '0;
        end else if (!arm) begin
            hits <= '0;
        end else if (tick) begin
            if (!level_act) begin
                hits <= '0;
            end else if (hits != HW'(QUAL_SAMPLES)) begin
                hits <= hits + 1'b1;
            end
        end
    end

    assign qualified = (hits == HW'(QUAL_SAMPLES));

    // R7: qualification only completes on a sample that saw the level active
    p_level_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qualified) |-> $past(level_act) && $past(tick));

    // R7: no qualification without being armed
    p_armed_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (hits == '0));

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import slpwk_pkg::*;
#(
    parameter int N_EXT        = 4,
    parameter int N_FAB        = 4,
    parameter int START_CYC    = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_SAMPLES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sleep_en,
    input  logic [1:0]             mode_sel,
    input  logic                   sleep_exec,
    input  logic [N_EXT-1:0]       ext_irq_n,
    input  logic [N_EXT-1:0]       ext_irq_en,
    input  logic [N_FAB-1:0]       fab_irq_n,
    input  logic [N_FAB-1:0]       fab_irq_en,
    input  logic [N_EXT+N_FAB-1:0] sense_edge,
    input  logic                   timer_irq,
    input  logic                   serial_irq,
    input  logic                   wdt_en,
    input  logic                   wdt_rst,
    input  logic                   ext_rst,
    input  logic                   slow_clk,
    output logic                   cpu_clk_en,
    output logic                   osc_stop,
    output logic                   wake_pulse,
    output logic                   rst_vec_sel
);

    localparam int N_LINES = N_EXT + N_FAB;
    localparam int CW      = $clog2(START_CYC + 1);

    slp_state_t    state, nxt;
    logic [CW-1:0] start_cnt;
    logic          rst_cause;
    logic          cause_set;
    logic          pin_req;
    logic          qualified;
    logic          reset_req;
    logic          in_deep;

    assign in_deep   = (state == ST_DEEP);
    assign reset_req = ext_rst | (wdt_rst & wdt_en);

    sw_pin_sense #(
        .N_LINES (N_LINES)
    ) i_pin_sense (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_n       ({fab_irq_n, ext_irq_n}),
        .pin_en      ({fab_irq_en, ext_irq_en}),
        .sense_edge  (sense_edge),
        .force_level (in_deep),
        .req_any     (pin_req)
    );

    sw_level_qual #(
        .SYNC_STAGES  (SYNC_STAGES),
        .QUAL_SAMPLES (QUAL_SAMPLES)
    ) i_level_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_clk  (slow_clk),
        .arm       (in_deep),
        .level_act (pin_req),
        .qualified (qualified)
    );

    // Next-state decision
    always_comb begin
        nxt       = state;
        cause_set = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (sleep_exec && sleep_en) begin
                    nxt = mode_is_deep(mode_sel) ? ST_DEEP : ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (reset_req) begin
                    nxt       = ST_WAKE;
                    cause_set = 1'b1;
                end else if (pin_req || timer_irq || serial_irq) begin
                    nxt = ST_WAKE;
                end
            end
            ST_DEEP: begin
                if (reset_req) begin
                    nxt       = ST_RESTART;
                    cause_set = 1'b1;
                end else if (qualified) begin
                    nxt = ST_RESTART;
                end
            end
            ST_RESTART: begin
                if (start_cnt == CW'(START_CYC - 1)) begin
                    nxt = ST_WAKE;
                end
            end
            ST_WAKE: nxt = ST_RUN;
            default: nxt = ST_RUN;
        endcase
    end

    // State register, start-up counter and wake cause
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            start_cnt <= '0;
            rst_cause <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_RESTART) begin
                start_cnt <= start_cnt + 1'b1;
            end else begin
                start_cnt <= '0;
            end
            if (state == ST_WAKE) begin
                rst_cause <= 1'b0;
            end else if (cause_set) begin
                rst_cause <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        cpu_clk_en  = 1'b0;
        osc_stop    = 1'b0;
        wake_pulse  = 1'b0;
        rst_vec_sel = 1'b0;
        unique case (state)
            ST_RUN:     cpu_clk_en = 1'b1;
            ST_IDLE:    cpu_clk_en = 1'b0;
            ST_DEEP:    osc_stop   = 1'b1;
            ST_RESTART: osc_stop   = 1'b0;
            ST_WAKE: begin
                cpu_clk_en  = 1'b1;
                wake_pulse  = 1'b1;
                rst_vec_sel = rst_cause;
            end
            default:    cpu_clk_en = 1'b1;
        endcase
    end

    // R2: a sleep strobe without the enable bit leaves the clock running
    p_sleep_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_exec && !sleep_en) |=> cpu_clk_en);

    // R3: entering light sleep keeps the oscillator running
    p_light_osc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_clk_en) && !mode_is_deep($past(mode_sel))) |-> !osc_stop);

    // R5: entering deep sleep stops the oscillator
    p_deep_osc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_clk_en) && mode_is_deep($past(mode_sel))) |-> osc_stop);

    // R8: oscillator restart precedes the strobe, clock still gated
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_stop) |-> (!cpu_clk_en && !wake_pulse));

    // R9: wake strobe is one cycle wide
    p_wake_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R9: clock runs during the strobe
    p_wake_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> cpu_clk_en);

    // R10: vector select only accompanies the strobe
    p_vec_with_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_vec_sel |-> wake_pulse);

endmodule

// File: tb/test_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module test_sleep_wake_ctrl;

    localparam int START_CYC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_en = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       sleep_exec = 1'b0;
    logic [3:0] ext_irq_n = 4'hF;
    logic [3:0] ext_irq_en = 4'h0;
    logic [3:0] fab_irq_n = 4'hF;
    logic [3:0] fab_irq_en = 4'h0;
    logic [7:0] sense_edge = 8'h00;
    logic       timer_irq = 1'b0;
    logic       serial_irq = 1'b0;
    logic       wdt_en = 1'b0;
    logic       wdt_rst = 1'b0;
    logic       ext_rst = 1'b0;
    logic       slow_clk = 1'b0;
    logic       cpu_clk_en, osc_stop, wake_pulse, rst_vec_sel;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sleep_wake_ctrl #(.START_CYC(START_CYC)) i_sleep_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .mode_sel(mode_sel),
        .sleep_exec(sleep_exec), .ext_irq_n(ext_irq_n), .ext_irq_en(ext_irq_en),
        .fab_irq_n(fab_irq_n), .fab_irq_en(fab_irq_en), .sense_edge(sense_edge),
        .timer_irq(timer_irq), .serial_irq(serial_irq), .wdt_en(wdt_en),
        .wdt_rst(wdt_rst), .ext_rst(ext_rst), .slow_clk(slow_clk),
        .cpu_clk_en(cpu_clk_en), .osc_stop(osc_stop), .wake_pulse(wake_pulse),
        .rst_vec_sel(rst_vec_sel)
    );

    // Light-sleep stimulus table
    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] ext_n;
        logic [3:0] ext_en;
        logic [3:0] fab_n;
        logic [3:0] fab_en;
        logic [7:0] sense;
        logic       tmr;
        logic       ser;
        logic       exp_wake;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 4'hE, 4'h1, 4'hF, 4'h0, 8'h00, 1'b0, 1'b0, 1'b1}, // ext0 low level
        '{2'b00, 4'hE, 4'h0, 4'hF, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0}, // ext0 disabled
        '{2'b00, 4'hF, 4'h0, 4'hF, 4'h0, 8'h00, 1'b1, 1'b0, 1'b1}, // timer
        '{2'b01, 4'hF, 4'h0, 4'hF, 4'h0, 8'h00, 1'b0, 1'b1, 1'b1}, // reserved mode, serial
        '{2'b00, 4'hF, 4'h0, 4'hB, 4'h4, 8'h40, 1'b0, 1'b0, 1'b1}, // fab2 falling edge
        '{2'b00, 4'hF, 4'hF, 4'hF, 4'hF, 8'h00, 1'b0, 1'b0, 1'b0}  // nothing active
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic enter_sleep(input logic [1:0] m);
        @(negedge clk);
        sleep_en = 1'b1; mode_sel = m; sleep_exec = 1'b1;
        @(negedge clk);
        sleep_en = 1'b0; sleep_exec = 1'b0;
    endtask

    task automatic wait_wake(output int lat, output logic rv);
        lat = 0; rv = 1'b0;
        for (int c = 1; c <= 40; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (wake_pulse) begin
                lat = c; rv = rst_vec_sel;
                break;
            end
        end
    endtask

    task automatic slow_pulse();
        @(negedge clk); slow_clk = 1'b1;
        repeat (4) @(negedge clk);
        slow_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_inputs();
        ext_irq_n = 4'hF; ext_irq_en = 4'h0; fab_irq_n = 4'hF; fab_irq_en = 4'h0;
        sense_edge = 8'h00; timer_irq = 1'b0; serial_irq = 1'b0;
        wdt_en = 1'b0; wdt_rst = 1'b0; ext_rst = 1'b0;
    endtask

    // Reset-path wake from any sleep, returns the latency
    task automatic force_out(output int lat, output logic rv);
        @(negedge clk); ext_rst = 1'b1;
        wait_wake(lat, rv);
        @(negedge clk); ext_rst = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int   lat;
        logic rv;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cpu_clk_en", cpu_clk_en, 1);
        chk("R1 osc_stop", osc_stop, 0);
        chk("R1 wake_pulse", wake_pulse, 0);
        chk("R1 rst_vec_sel", rst_vec_sel, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 sleep strobe without enable
        sleep_exec = 1'b1; mode_sel = 2'b10;
        @(negedge clk); sleep_exec = 1'b0;
        chk("R2 ignored strobe clk", cpu_clk_en, 1);
        chk("R2 ignored strobe osc", osc_stop, 0);

        // Table walk: light sleep (R3, R4, R11)
        for (int i = 0; i < NV; i++) begin
            enter_sleep(VEC[i].mode);
            chk($sformatf("R3 row%0d clk gated", i), cpu_clk_en, 0);
            chk($sformatf("R3 row%0d osc on", i), osc_stop, 0);
            ext_irq_n = VEC[i].ext_n; ext_irq_en = VEC[i].ext_en;
            fab_irq_n = VEC[i].fab_n; fab_irq_en = VEC[i].fab_en;
            sense_edge = VEC[i].sense; timer_irq = VEC[i].tmr; serial_irq = VEC[i].ser;
            if (VEC[i].exp_wake) begin
                wait_wake(lat, rv);
                chk($sformatf("R4 R11 row%0d latency", i), lat, 1);
                chk($sformatf("R10 row%0d irq vector", i), rv, 0);
                @(negedge clk);
                chk($sformatf("R9 row%0d pulse ends", i), wake_pulse, 0);
                clear_inputs();
            end else begin
                repeat (3) @(negedge clk);
                chk($sformatf("R4 row%0d no wake", i), cpu_clk_en, 0);
                clear_inputs();
                force_out(lat, rv);
                chk($sformatf("R10 R11 row%0d idle reset", i), lat, 1);
                chk($sformatf("R10 row%0d reset vector", i), rv, 1);
            end
        end

        // R4 edge sense: line already low does not wake light sleep
        ext_irq_n = 4'hE; ext_irq_en = 4'h1; sense_edge = 8'h01;
        repeat (2) @(negedge clk);
        enter_sleep(2'b00);
        repeat (4) @(negedge clk);
        chk("R4 held-low edge line", cpu_clk_en, 0);
        force_out(lat, rv);

        // R5 R6 R7 R8: same held-low edge line wakes deep sleep as a level
        enter_sleep(2'b10);
        chk("R5 deep clk gated", cpu_clk_en, 0);
        chk("R5 deep osc stopped", osc_stop, 1);
        slow_pulse();
        chk("R7 one sample no wake", osc_stop, 1);
        @(negedge clk); slow_clk = 1'b1;
        wait_wake(lat, rv);
        chk("R6 R7 R8 R11 level wake latency", lat, START_CYC + 4);
        chk("R10 level wake vector", rv, 0);
        slow_clk = 1'b0;
        clear_inputs();
        repeat (4) @(negedge clk);

        // R7: request gone at second sample, power-save mode
        fab_irq_en = 4'h2; fab_irq_n = 4'hD;
        enter_sleep(2'b11);
        chk("R5 save osc stopped", osc_stop, 1);
        slow_pulse();
        fab_irq_n = 4'hF;
        slow_pulse();
        fab_irq_n = 4'hD;
        slow_pulse();
        chk("R7 broken run no wake", osc_stop, 1);
        fab_irq_n = 4'hF;
        @(negedge clk); ext_rst = 1'b1;
        wait_wake(lat, rv);
        chk("R10 R11 deep reset latency", lat, START_CYC + 1);
        chk("R10 deep reset vector", rv, 1);
        @(negedge clk); ext_rst = 1'b0;
        clear_inputs();

        // R6 R10: ignored sources in deep sleep
        enter_sleep(2'b10);
        timer_irq = 1'b1; serial_irq = 1'b1; ext_irq_n = 4'hB; ext_irq_en = 4'h0;
        slow_pulse();
        slow_pulse();
        chk("R6 timer serial disabled pin ignored", osc_stop, 1);
        wdt_rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 wdt reset without enable", osc_stop, 1);
        wdt_en = 1'b1;
        wait_wake(lat, rv);
        chk("R10 R11 wdt wake latency", lat, START_CYC + 1);
        chk("R10 wdt vector", rv, 1);
        @(negedge clk);
        chk("R9 clock after wake", cpu_clk_en, 1);
        clear_inputs();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule